// File: doc/BRIEF.md
# Dual-output overlap delay generator

This block turns a single PWM gate request into two in-phase gate drives for a forward converter with an active clamp. The main output switches the primary device. The auxiliary output switches the clamp or reset device, or a synchronous rectifier when it is inverted outside the block. The auxiliary output always brackets the main one. It turns on a programmed number of clock cycles before the main output and turns off the same number of cycles after it. A fault strobe overrides all of this and pulls both gates low without any delay.

The delay is given in clock cycles. A setting of zero selects a default that corresponds to 200 ns at the configured clock. A setting below the shortest supported delay, about 80 ns, is raised to that floor. The block also compares twice the effective delay with the off time implied by the current period and maximum on-time. It raises a flag when the auxiliary output could otherwise be driven to full duty.

Top module: `odg_overlap_gen`

## Requirements
- R1: When the request is sampled high with both outputs low, aux_o rises after that clock edge and main_o rises exactly d cycles later, provided the request is still high. Here d is the effective delay.
- R2: When the request is sampled low while main_o is high, main_o falls after that edge and aux_o falls exactly d cycles later. For a request held high for H cycles, aux_o is high for H+d cycles and main_o is high for H−d cycles.
- R3: main_o is never high while aux_o is low.
- R4: While fault_i is high, both outputs are low in the same cycle, combinationally. The sequencer returns to idle. After fault_i drops, a request that is still high starts a fresh sequence with aux_o only.
- R5: dly_bad_o is 1 when max_on_i ≥ period_i, or when 2·d > period_i − max_on_i. Otherwise it is 0. It is combinational from dly_cfg_i, period_i and max_on_i.
- R6: The effective delay d is derived from dly_cfg_i as follows. A value of 0 gives the default, 50 cycles at 250 MHz. A value below the floor, 20 cycles at 250 MHz, gives the floor. Any other value is used as is.
- R7: If the request falls within d cycles of aux_o rising (H ≤ d), main_o never rises. aux_o still stays high for d cycles after the request is sampled low, H+d cycles in total.
- R8: The delay value is captured only while both outputs are low. A change to dly_cfg_i during a pulse does not alter that pulse's trailing delay.
- R9: Reset (rst_ni low, asynchronous) forces both outputs low at once and clears the sequencer and its counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_req_i | input | 1 | Raw PWM gate request |
| fault_i | input | 1 | Fast shutdown strobe, active high |
| dly_cfg_i | input | DLY_W | Overlap delay in cycles; 0 selects the default |
| period_i | input | PER_W | Switching period in cycles, used for the limit check |
| max_on_i | input | PER_W | Maximum on-time in cycles, used for the limit check |
| main_o | output | 1 | Primary switch gate |
| aux_o | output | 1 | Clamp/reset or rectifier gate |
| dly_bad_o | output | 1 | Delay setting exceeds half the minimum off time |

## Verification
A wrong sequencer state or counter value shows up at the ports within one pulse, as an error in one of four measured quantities. These are the lead gap, the trail gap, the main pulse width and the aux pulse width. Each of them is compared cycle for cycle against d, H−d and H+d. A delay latched at the wrong time appears as a trail gap equal to the new setting instead of the old one. A stuck fault path shows up as a gate still high one cycle after the strobe, or as a restart that drives main_o without the lead gap.

// File: rtl/odg_pkg.sv
package odg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_ON    = 2'd2,
    ST_TRAIL = 2'd3
  } odg_state_e;
endpackage

// File: rtl/odg_dly_sel.sv
module odg_dly_sel #(
  parameter int DLY_W   = 8,
  parameter int PER_W   = 12,
  parameter int DFLT_CYC = 50,
  parameter int MIN_CYC  = 20
) (
  input  logic [DLY_W-1:0] cfg_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [PER_W-1:0] max_on_i,
  output logic [DLY_W-1:0] eff_o,
  output logic             bad_o
);
  localparam int CW = ((PER_W > DLY_W) ? PER_W : DLY_W) + 2;
  localparam logic [DLY_W-1:0] DFLT_V = DLY_W'(DFLT_CYC);
  localparam logic [DLY_W-1:0] MIN_V  = DLY_W'(MIN_CYC);

  logic [CW-1:0] twice_d;
  logic [CW-1:0] off_w;

  always_comb begin
    if (cfg_i == '0)        eff_o = DFLT_V;
    else if (cfg_i < MIN_V) eff_o = MIN_V;
    else                    eff_o = cfg_i;
  end

  assign twice_d = CW'(eff_o) << 1;
  assign off_w   = CW'(period_i) - CW'(max_on_i);
  assign bad_o   = (max_on_i >= period_i) || (twice_d > off_w);
endmodule

// File: rtl/odg_edge_seq.sv
module odg_edge_seq
  import odg_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             fault_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             main_q_o,
  output logic             aux_q_o
);
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  odg_state_e       state_q;
  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] dly_q;
  logic             main_q, aux_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      dly_q   <= '0;
      main_q  <= 1'b0;
      aux_q   <= 1'b0;
    end else if (fault_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      dly_q   <= dly_i;
      main_q  <= 1'b0;
      aux_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          dly_q <= dly_i;
          if (req_i) begin
            aux_q   <= 1'b1;
            cnt_q   <= dly_i;
            state_q <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (!req_i) begin
            cnt_q   <= dly_q;      // short pulse: main never fires
            state_q <= ST_TRAIL;
          end else if (cnt_q == ONE) begin
            main_q  <= 1'b1;
            state_q <= ST_ON;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        ST_ON: begin
          if (!req_i) begin
            main_q  <= 1'b0;
            cnt_q   <= dly_q;
            state_q <= ST_TRAIL;
          end
        end
        ST_TRAIL: begin
          if (cnt_q == ONE) begin
            aux_q   <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign main_q_o = main_q;
  assign aux_q_o  = aux_q;

  p_rise_order_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(main_q) |-> $past(aux_q));

  p_fall_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(aux_q) && !$past(fault_i)) |-> !$past(main_q));

  p_fault_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(fault_i) |-> (!main_q && !aux_q && state_q == ST_IDLE));

  p_dly_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && !fault_i) |=> $stable(dly_q));
endmodule

// File: rtl/odg_overlap_gen.sv
module odg_overlap_gen #(
  parameter int CLK_MHZ = 250,
  parameter int DFLT_NS = 200,
  parameter int MIN_NS  = 80,
  parameter int DLY_W   = 8,
  parameter int PER_W   = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwm_req_i,
  input  logic             fault_i,
  input  logic [DLY_W-1:0] dly_cfg_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [PER_W-1:0] max_on_i,
  output logic             main_o,
  output logic             aux_o,
  output logic             dly_bad_o
);
  localparam int DFLT_RAW = (DFLT_NS * CLK_MHZ + 999) / 1000;
  localparam int MIN_RAW  = (MIN_NS * CLK_MHZ + 999) / 1000;
  localparam int MIN_CYC  = (MIN_RAW < 1) ? 1 : MIN_RAW;
  localparam int DFLT_CYC = (DFLT_RAW < MIN_CYC) ? MIN_CYC : DFLT_RAW;

  logic [DLY_W-1:0] dly_eff;
  logic             main_q, aux_q;

  odg_dly_sel #(
    .DLY_W(DLY_W), .PER_W(PER_W), .DFLT_CYC(DFLT_CYC), .MIN_CYC(MIN_CYC)
  ) u_dly_sel (
    .cfg_i(dly_cfg_i), .period_i(period_i), .max_on_i(max_on_i),
    .eff_o(dly_eff), .bad_o(dly_bad_o)
  );

  odg_edge_seq #(.DLY_W(DLY_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(pwm_req_i), .fault_i(fault_i),
    .dly_i(dly_eff), .main_q_o(main_q), .aux_q_o(aux_q)
  );

  // fast kill bypasses the registers
  assign main_o = main_q & ~fault_i;
  assign aux_o  = aux_q  & ~fault_i;

  p_in_phase_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_o |-> aux_o);

  p_eff_floor_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dly_eff >= DLY_W'(MIN_CYC));
endmodule

// File: tb/odg_overlap_gen_tb.sv
module odg_overlap_gen_tb;
  localparam int DLY_W = 8;
  localparam int PER_W = 12;
  localparam int NV = 8;
  localparam int V_CFG [NV] = '{0, 20, 20, 30, 20, 100, 5, 255};
  localparam int V_HI  [NV] = '{80, 40, 20, 10, 21, 150, 30, 300};

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic pwm_req_i = 1'b0;
  logic fault_i = 1'b0;
  logic [DLY_W-1:0] dly_cfg_i = '0;
  logic [PER_W-1:0] period_i = 12'd250;
  logic [PER_W-1:0] max_on_i = 12'd150;
  logic main_o, aux_o, dly_bad_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  odg_overlap_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwm_req_i(pwm_req_i), .fault_i(fault_i),
    .dly_cfg_i(dly_cfg_i), .period_i(period_i), .max_on_i(max_on_i),
    .main_o(main_o), .aux_o(aux_o), .dly_bad_o(dly_bad_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_d(input int cfg);
    if (cfg == 0) return 50;
    if (cfg < 20) return 20;
    return cfg;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    idle(3);
    chk("R9 reset main", main_o, 0);
    chk("R9 reset aux", aux_o, 0);
    rst_ni = 1'b1;
    idle(2);

    // table walk: R1 R2 R3 R6 R7
    for (int v = 0; v < NV; v++) begin
      int d, h, aux_w, main_w, lead, trail, bad_ph;
      bit seen;
      d = exp_d(V_CFG[v]); h = V_HI[v];
      aux_w = 0; main_w = 0; lead = 0; trail = 0; bad_ph = 0; seen = 0;
      dly_cfg_i = DLY_W'(V_CFG[v]);
      @(negedge clk_i);
      pwm_req_i = 1'b1;
      for (int i = 1; i <= h + d + 4; i++) begin
        @(negedge clk_i);
        if (aux_o) aux_w++;
        if (main_o) begin main_w++; seen = 1; end
        if (aux_o && !main_o && !seen) lead++;
        if (aux_o && !main_o && seen) trail++;
        if (main_o && !aux_o) bad_ph++;
        if (i == h) pwm_req_i = 1'b0;
      end
      chk("R2 aux width", aux_w, h + d);
      chk("R3 polarity", bad_ph, 0);
      if (h > d) begin
        chk("R1 lead gap (R6 delay)", lead, d);
        chk("R2 trail gap", trail, d);
        chk("R2 main width", main_w, h - d);
      end else begin
        chk("R7 main suppressed", main_w, 0);
      end
      idle(2);
    end

    // R4 fault kill
    dly_cfg_i = 8'd20;
    @(negedge clk_i); pwm_req_i = 1'b1;
    idle(30);
    chk("R4 pre-fault main", main_o, 1);
    fault_i = 1'b1; #1;
    chk("R4 kill main", main_o, 0);
    chk("R4 kill aux", aux_o, 0);
    @(negedge clk_i);
    chk("R4 held main", main_o, 0);
    fault_i = 1'b0;
    @(negedge clk_i);
    chk("R4 restart aux", aux_o, 1);
    chk("R4 restart main", main_o, 0);
    pwm_req_i = 1'b0;
    idle(30);
    chk("R4 drained aux", aux_o, 0);

    // R8 mid-pulse delay change
    begin
      int tr;
      tr = 0;
      dly_cfg_i = 8'd20;
      @(negedge clk_i); pwm_req_i = 1'b1;
      idle(30);
      dly_cfg_i = 8'd100;
      idle(10);
      pwm_req_i = 1'b0;
      for (int i = 0; i < 120; i++) begin
        @(negedge clk_i);
        if (aux_o) tr++;
      end
      chk("R8 trail keeps old delay", tr, 20);
    end

    // R9 reset mid-pulse
    dly_cfg_i = 8'd20;
    @(negedge clk_i); pwm_req_i = 1'b1;
    idle(30);
    rst_ni = 1'b0; #1;
    chk("R9 async main", main_o, 0);
    chk("R9 async aux", aux_o, 0);
    @(negedge clk_i);
    pwm_req_i = 1'b0; rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R9 after release aux", aux_o, 0);

    // R5 limit flag
    period_i = 12'd250; max_on_i = 12'd200; dly_cfg_i = 8'd25; #1;
    chk("R5 at limit", dly_bad_o, 0);
    dly_cfg_i = 8'd26; #1;
    chk("R5 over limit", dly_bad_o, 1);
    dly_cfg_i = 8'd0; #1;
    chk("R5 default over", dly_bad_o, 1);
    max_on_i = 12'd250; dly_cfg_i = 8'd20; #1;
    chk("R5 full duty", dly_bad_o, 1);
    max_on_i = 12'd100; dly_cfg_i = 8'd5; #1;
    chk("R5 floor ok", dly_bad_o, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule